// File: doc/BRIEF.md
# Serial Control and Status Shifter for an Eight-Channel Driver

This block is the serial slave in front of an eight-channel low-side driver. A host selects it by pulling chip select low, clocks in one control bit per channel, and releases chip select to apply the new word to the channel latch. When chip select is pulled low, the same shift register is loaded with the eight per-channel status bits, and the host reads them back on the serial output while it writes the next control word.

The serial pins are asynchronous to the block. They pass through small synchronizers and are reduced to edge events in the system clock domain, so the serial clock must run at no more than a quarter of the system clock. A bit counter guards the latch: a frame takes effect only when its length is a whole number of words. A longer frame passes the oldest bits on to the serial output, so several devices can share one chip select in a chain.

Top module: `drv_spi_shifter`

## Requirements
- R1: While `rst_n_i` is low, `ctl_o` reads all ones (every channel off) from the next system clock on, and a frame sent during reset leaves it all ones.
- R2: A frame's bits are captured on falling serial clock edges. The first bit of the last eight lands in `ctl_o[7]` and the eighth in `ctl_o[0]`. A 0 bit means the channel is on and a 1 bit means it is off.
- R3: `ctl_o` changes only on the rising edge of chip select, and only when the number of falling serial clock edges since chip select fell is a nonzero multiple of 8. Any other frame length leaves `ctl_o` unchanged.
- R4: A frame of 16 bits or another larger multiple of 8 latches the last eight bits received. A frame with no clock edges latches nothing.
- R5: On the falling edge of chip select, `status_i` is loaded into the shift register with channel 7 in the MSB. `so_o` then presents `status_i[7]`, and each rising serial clock edge presents the next bit, MSB first, so the host reads status bit 7-j at the j-th falling edge.
- R6: In a frame longer than eight bits, the bit read at falling edge j (counting from 0, for j of at least 8) is the input bit sent at position j-8.
- R7: While chip select is high, `so_oe_o` is low, and serial clock and data activity has no effect on `ctl_o`.
- R8: `so_oe_o` follows chip select and is not affected by reset: with chip select low and `rst_n_i` low, `so_oe_o` is high.
- R9: While `uv_i` is high, the block behaves as if reset were asserted, and `ctl_o` reads all ones from the next system clock on.
- R10: The bit counter saturates at 2^CNT_W-1 (255 by default), a value that is not a multiple of 8. A frame of 256 bits leaves `ctl_o` unchanged, while a frame of 128 bits latches its last eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least four times the serial clock rate |
| rst_n_i | input | 1 | Active-low reset |
| uv_i | input | 1 | Undervoltage flag; active high, acts as reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csb_i | input | 1 | Chip select, active low, asynchronous |
| si_i | input | 1 | Serial data in |
| status_i | input | CHANNELS | Per-channel status, captured when chip select falls |
| ctl_o | output | CHANNELS | Latched control word, 1 = channel off |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data pad; low means high impedance |

## Verification
The bench goes after frame lengths just off a word boundary (7, 9, 12 and 15 bits) and the empty frame. A counter that compares against 8 only, or that latches on any chip select release, would then overwrite the channel latch. It sends 16-bit and 128-bit frames to show that the last word wins and that the oldest bits come back out after an eight-bit delay, which an off-by-one shift or a wrong output edge would break by moving each bit by one position. A 256-bit frame drives the counter into saturation; a counter that wraps would land on zero or a multiple of eight and latch. Reset and undervoltage are checked for forcing every channel off without disturbing the output enable, and idle serial clock toggling with chip select high is checked for leaving the latch and enable alone.

// File: rtl/dss_pkg.sv
package dss_pkg;

   // Synchronized pin level with its single-cycle edge events.
   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } dss_sig_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dss_sync_edge.sv
module dss_sync_edge #(
   parameter int unsigned STAGES  = 2,
   parameter bit          HAS_RST = 1'b1,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              pin_i,
   output dss_pkg::dss_sig_t sig_o
);

   if (STAGES < 2 || STAGES > 3) begin : g_bad_stages
      $error("dss_sync_edge: STAGES must be 2 or 3");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   // The reset variant is chosen per pin: pins whose path must ignore
   // reset use the plain chain.
   if (HAS_RST) begin : g_rst
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            chain_q <= {STAGES{RST_VAL}};
            last_q  <= RST_VAL;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            last_q  <= chain_q[STAGES-1];
         end
      end
   end else begin : g_norst
      always_ff @(posedge clk_i) begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign sig_o.lvl  = chain_q[STAGES-1];
   assign sig_o.rise = chain_q[STAGES-1] & ~last_q;
   assign sig_o.fall = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/dss_frame_cnt.sv
module dss_frame_cnt #(
   parameter int unsigned WORD  = 8,
   parameter int unsigned CNT_W = 8
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic inc_i,
   output logic whole_o
);

   localparam int unsigned LOW_W = $clog2(WORD);
   localparam logic [CNT_W-1:0] SAT = '1;

   if (!dss_pkg::is_pow2(WORD) || WORD < 2) begin : g_bad_word
      $error("dss_frame_cnt: WORD must be a power of two, at least 2");
   end
   if (CNT_W <= LOW_W) begin : g_bad_cnt
      $error("dss_frame_cnt: CNT_W too narrow for WORD");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && cnt_q != SAT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // SAT is odd, so a saturated count is never a whole number of words.
   assign whole_o = (cnt_q != '0) && (cnt_q[LOW_W-1:0] == '0) && (cnt_q != SAT);

   // R10: once saturated the count stays put until the next frame start.
   p_cnt_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_q == SAT && !clr_i) |=> (cnt_q == SAT));

endmodule

// File: rtl/dss_shift_reg.sv
module dss_shift_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic             shift_i,
   input  logic             ser_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("dss_shift_reg: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] sr_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= load_val_i;
      end else if (shift_i) begin
         sr_q <= {sr_q[WIDTH-2:0], ser_i};
      end
   end

   assign q_o = sr_q;

endmodule

// File: rtl/drv_spi_shifter.sv
module drv_spi_shifter #(
   parameter int unsigned CHANNELS    = 8,
   parameter int unsigned MAX_WORDS   = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_n_i,
   input  logic                uv_i,
   input  logic                sclk_i,
   input  logic                csb_i,
   input  logic                si_i,
   input  logic [CHANNELS-1:0] status_i,
   output logic [CHANNELS-1:0] ctl_o,
   output logic                so_o,
   output logic                so_oe_o
);

   localparam int unsigned CNT_W = $clog2(CHANNELS * MAX_WORDS + 1);
   localparam int unsigned MSB   = CHANNELS - 1;

   if (MAX_WORDS < 1) begin : g_bad_words
      $error("drv_spi_shifter: MAX_WORDS must be at least 1");
   end

   dss_pkg::dss_sig_t sclk_s, csb_s, si_s;
   logic              int_rst;
   logic              sel;
   logic              shift_ev, out_ev;
   logic              whole;
   logic              latch_go;
   logic [MSB:0]      sr;
   logic [MSB:0]      ctl_q;
   logic              so_q;

   assign int_rst = ~rst_n_i | uv_i;

   dss_sync_edge #(.STAGES(SYNC_STAGES), .HAS_RST(1'b1), .RST_VAL(1'b0)) i_sync_sclk (
      .clk_i(clk_i), .rst_i(int_rst), .pin_i(sclk_i), .sig_o(sclk_s));

   dss_sync_edge #(.STAGES(SYNC_STAGES), .HAS_RST(1'b1), .RST_VAL(1'b0)) i_sync_si (
      .clk_i(clk_i), .rst_i(int_rst), .pin_i(si_i), .sig_o(si_s));

   // Chip select drives the output enable, which must ignore reset.
   dss_sync_edge #(.STAGES(SYNC_STAGES), .HAS_RST(1'b0), .RST_VAL(1'b1)) i_sync_csb (
      .clk_i(clk_i), .rst_i(int_rst), .pin_i(csb_i), .sig_o(csb_s));

   assign sel      = ~csb_s.lvl;
   assign shift_ev = sel & sclk_s.fall;
   assign out_ev   = sel & sclk_s.rise;

   dss_frame_cnt #(.WORD(CHANNELS), .CNT_W(CNT_W)) i_cnt (
      .clk_i(clk_i), .rst_i(int_rst), .clr_i(csb_s.fall),
      .inc_i(shift_ev), .whole_o(whole));

   dss_shift_reg #(.WIDTH(CHANNELS)) i_sr (
      .clk_i(clk_i), .rst_i(int_rst), .load_i(csb_s.fall),
      .load_val_i(status_i), .shift_i(shift_ev), .ser_i(si_s.lvl), .q_o(sr));

   // Output bit: status MSB right after select, then the register MSB
   // on every rising serial clock; no reset on this path.
   always_ff @(posedge clk_i) begin
      if (csb_s.fall) begin
         so_q <= status_i[MSB];
      end else if (out_ev) begin
         so_q <= sr[MSB];
      end
   end

   assign latch_go = csb_s.rise & whole;

   always_ff @(posedge clk_i) begin
      if (int_rst) begin
         ctl_q <= '1;
      end else if (latch_go) begin
         ctl_q <= sr;
      end
   end

   assign ctl_o   = ctl_q;
   assign so_o    = so_q;
   assign so_oe_o = ~csb_s.lvl;

   // R1: reset pin forces every channel off one clock later.
   p_ctl_reset_r1: assert property (@(posedge clk_i)
      !rst_n_i |=> (ctl_o == '1));

   // R9: undervoltage acts like reset.
   p_uv_off_r9: assert property (@(posedge clk_i)
      uv_i |=> (ctl_o == '1));

   // R3: the latch moves only when a whole-word frame closes.
   p_ctl_change_r3: assert property (@(posedge clk_i) disable iff (int_rst)
      (ctl_q != $past(ctl_q)) |-> $past(latch_go));

   // R7: chip select held high for the synchronizer depth disables SO.
   p_so_hiz_r7: assert property (@(posedge clk_i)
      (csb_i && $past(csb_i) && $past(csb_i, 2) && $past(csb_i, 3)) |-> !so_oe_o);

   // R8: chip select held low enables SO whatever the reset state.
   p_so_en_r8: assert property (@(posedge clk_i)
      (!csb_i && !$past(csb_i) && !$past(csb_i, 2) && !$past(csb_i, 3)) |-> so_oe_o);

endmodule

// File: tb/test_drv_spi_shifter.sv
module test_drv_spi_shifter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       uv = 1'b0;
   logic       sclk = 1'b0;
   logic       csb = 1'b1;
   logic       si = 1'b0;
   logic [7:0] status = 8'h00;
   logic [7:0] ctl;
   logic       so;
   logic       so_oe;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [255:0] so_cap;
   logic [255:0] sent;
   logic [7:0]   exp_ctl;

   always #2 clk = ~clk;

   drv_spi_shifter i_drv_spi_shifter (
      .clk_i(clk), .rst_n_i(rst_n), .uv_i(uv), .sclk_i(sclk), .csb_i(csb),
      .si_i(si), .status_i(status), .ctl_o(ctl), .so_o(so), .so_oe_o(so_oe));

   // {bit count, data sent MSB first, status}
   localparam int NV = 11;
   localparam logic [28:0] VEC [NV] = '{
      {5'd8,  16'h00A5, 8'h3C},
      {5'd8,  16'h005A, 8'hC3},
      {5'd7,  16'h0011, 8'h0F},
      {5'd9,  16'h01FF, 8'hF0},
      {5'd16, 16'hABCD, 8'h81},
      {5'd0,  16'h0000, 8'h55},
      {5'd12, 16'h0F0F, 8'hAA},
      {5'd8,  16'h0000, 8'h00},
      {5'd15, 16'h7FFF, 8'h7E},
      {5'd16, 16'h12FE, 8'h18},
      {5'd8,  16'h00FF, 8'hFF}
   };

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input int nbits, input logic [15:0] data);
      csb = 1'b0;
      wait_n(6);
      for (int j = 0; j < nbits; j++) begin
         int   p;
         logic b;
         p = nbits - 1 - j;
         b = (p < 16) ? data[p] : p[0];
         si = b;
         sent[j] = b;
         wait_n(1);
         sclk = 1'b1;
         wait_n(5);
         so_cap[j] = so;
         sclk = 1'b0;
         wait_n(5);
      end
      csb = 1'b1;
      wait_n(6);
   endtask

   initial begin
      wait_n(5);
      check("R1 ctl in reset", {24'h0, ctl}, 32'hFF);
      check("R7 so_oe idle", {31'h0, so_oe}, 32'h0);
      rst_n = 1'b1;
      wait_n(3);
      exp_ctl = 8'hFF;

      for (int v = 0; v < NV; v++) begin
         int         nb;
         logic [7:0] st;
         logic [15:0] exp_so;
         logic [15:0] got_so;
         nb = int'(VEC[v][28:24]);
         st = VEC[v][7:0];
         status = st;
         send(nb, VEC[v][23:8]);
         if (nb != 0 && nb % 8 == 0) exp_ctl = VEC[v][15:8];
         check("R2 R3 R4 latch", {24'h0, ctl}, {24'h0, exp_ctl});
         exp_so = '0;
         got_so = '0;
         for (int j = 0; j < nb; j++) begin
            exp_so[j] = (j < 8) ? st[7-j] : sent[j-8];
            got_so[j] = so_cap[j];
         end
         check("R5 R6 serial out", {16'h0, got_so}, {16'h0, exp_so});
      end

      // R7: activity with chip select high is ignored
      for (int k = 0; k < 12; k++) begin
         si = k[0];
         sclk = 1'b1;
         wait_n(4);
         sclk = 1'b0;
         wait_n(4);
      end
      check("R7 ctl unchanged", {24'h0, ctl}, {24'h0, exp_ctl});
      check("R7 so_oe low", {31'h0, so_oe}, 32'h0);

      // R10: saturated frame rejected, long whole frame accepted
      status = 8'h00;
      send(256, 16'h0000);
      check("R10 256-bit frame", {24'h0, ctl}, {24'h0, exp_ctl});
      send(128, 16'h0033);
      exp_ctl = 8'h33;
      check("R10 128-bit frame", {24'h0, ctl}, {24'h0, exp_ctl});
      check("R6 chained bit", {31'h0, so_cap[127]}, {31'h0, sent[119]});

      // R1: frame during reset does not latch
      send(8, 16'h0000);
      check("R2 all on", {24'h0, ctl}, 32'h00);
      rst_n = 1'b0;
      wait_n(2);
      check("R1 reset forces off", {24'h0, ctl}, 32'hFF);
      send(8, 16'h0000);
      check("R1 frame in reset", {24'h0, ctl}, 32'hFF);
      rst_n = 1'b1;
      wait_n(3);

      // R9: undervoltage
      send(8, 16'h000F);
      check("R3 relatch", {24'h0, ctl}, 32'h0F);
      uv = 1'b1;
      wait_n(2);
      check("R9 uv forces off", {24'h0, ctl}, 32'hFF);
      uv = 1'b0;
      wait_n(2);
      check("R9 after uv", {24'h0, ctl}, 32'hFF);

      // R8: output enable ignores reset
      csb = 1'b0;
      rst_n = 1'b0;
      wait_n(6);
      check("R8 so_oe in reset", {31'h0, so_oe}, 32'h1);
      csb = 1'b1;
      wait_n(6);
      check("R7 so_oe released", {31'h0, so_oe}, 32'h0);
      rst_n = 1'b1;
      wait_n(3);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule